// File: doc/BRIEF.md
# Port Level-Change Detector

This block watches the upper half of an 8-bit input port. It raises one sticky flag when any of those pins has a level that differs from a stored snapshot of the port. It also gives the CPU the synchronized port value to read. The snapshot is not the pin value from the previous clock. It is refreshed only when the CPU reads the port. Software therefore sees a change against the last value it read, and it re-arms the detector by reading the port and then clearing the flag.

The raw pins pass through a two-stage synchronizer. The synchronized value feeds both the read data and the comparison. Each of the four watched pins has its own enable bit. A pin whose enable bit is low can never raise the flag. A read updates the snapshot in the same cycle. A change that first reaches the comparison during a read cycle is therefore absorbed into the snapshot and goes unreported, as intended. The flag goes to an interrupt output through a separate enable input.

All pins are plain level or strobe signals. There is no stream interface, so there is no back-pressure: a read strobe takes effect in the cycle it is asserted, and the read data is present at every cycle.

Top module: `port_change_detect`

## Requirements
- R1: `rd_data_o` shows `pins_i` after two clock edges. A change applied before edge k appears on `rd_data_o` after edge k+1.
- R2: Pins 0 to 3 never set `chg_flag_o`, whatever the state of the enables.
- R3: When an enabled watched pin (pins 4 to 7) differs from the snapshot, `chg_flag_o` rises at the next edge. This is the third edge after the pin change. No read may occur in that cycle.
- R4: `chg_en_i[k]` enables pin 4+k. While that bit is 0, a change on that pin does not set the flag. If the bit is later set while the pin still differs from the snapshot, the flag rises at the next edge.
- R5: A cycle with `rd_stb_i` high copies synchronized pins 4 to 7 into the snapshot and does not set the flag. A change that reaches the comparison in that same cycle is lost. A later return of the pin to its earlier level is reported, because the snapshot now holds the new level.
- R6: The flag holds until a cycle with `flag_clr_i` high. A clear does not take effect in a cycle that also meets the set condition of R3 or R4.
- R7: While `rst_i` is high (synchronous, held at least 2 cycles), the flag is 0 and the snapshot follows the synchronized pins. With steady pins, no change is flagged after reset.
- R8: `irq_o` is high exactly when `chg_flag_o` and `irq_en_i` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| pins_i | input | 8 | Asynchronous port pin levels |
| chg_en_i | input | 4 | Per-pin change enables for pins 4 to 7 |
| rd_stb_i | input | 1 | Port read strobe, refreshes the snapshot |
| flag_clr_i | input | 1 | Clears the sticky change flag |
| irq_en_i | input | 1 | Enables the flag onto the interrupt output |
| rd_data_o | output | 8 | Synchronized port value |
| chg_flag_o | output | 1 | Sticky change flag |
| irq_o | output | 1 | Gated interrupt request |

## Verification
The hardest case to reach is the lost change. It needs a read strobe in the one cycle in which a new pin level has just left the synchronizer. The bench changes a pin on a falling edge and waits exactly two rising edges. It then raises the read strobe for one cycle and checks that the flag stays low. It then drives the pin back and checks that the flag rises, which shows that the snapshot took the new level. A read and a clear in the same cycle as a fresh mismatch are also driven at that exact cycle.

// File: rtl/port_chg_pkg.sv
package port_chg_pkg;
  localparam int unsigned SYNC_MIN = 2;

  function automatic logic masked_diff(input logic [31:0] a,
                                       input logic [31:0] b,
                                       input logic [31:0] m);
    return |((a ^ b) & m);
  endfunction
endpackage

// File: rtl/pcd_sync.sv
module pcd_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i) stage_q[0] <= d_i;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i) stage_q[s] <= stage_q[s-1];
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pcd_compare.sv
module pcd_compare
  import port_chg_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         load_i,
  input  logic [W-1:0] live_i,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] snap_o,
  output logic         diff_o
);
  logic [W-1:0] snap_q;

  always_ff @(posedge clk_i) begin
    if (load_i) snap_q <= live_i;
  end

  assign snap_o = snap_q;
  assign diff_o = masked_diff(32'(live_i), 32'(snap_q), 32'(en_i));
endmodule

// File: rtl/pcd_flag.sv
module pcd_flag (
  input  logic clk_i,
  input  logic rst_i,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)      flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/port_change_detect.sv
module port_change_detect
  import port_chg_pkg::*;
#(
  parameter int unsigned PORT_W      = 8,
  parameter int unsigned MON_LSB     = 4,
  parameter int unsigned SYNC_STAGES = SYNC_MIN,
  localparam int unsigned MON_W      = PORT_W - MON_LSB
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [PORT_W-1:0] pins_i,
  input  logic [MON_W-1:0]  chg_en_i,
  input  logic              rd_stb_i,
  input  logic              flag_clr_i,
  input  logic              irq_en_i,
  output logic [PORT_W-1:0] rd_data_o,
  output logic              chg_flag_o,
  output logic              irq_o
);
  logic [PORT_W-1:0] pins_s;
  logic [MON_W-1:0]  snap;
  logic              mism;
  logic              set_c;

  pcd_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .d_i   (pins_i),
    .q_o   (pins_s)
  );

  pcd_compare #(.W(MON_W)) u_cmp (
    .clk_i  (clk_i),
    .load_i (rst_i | rd_stb_i),
    .live_i (pins_s[PORT_W-1:MON_LSB]),
    .en_i   (chg_en_i),
    .snap_o (snap),
    .diff_o (mism)
  );

  // a read absorbs a coincident change into the snapshot, so it cannot set
  assign set_c = mism & ~rd_stb_i;

  pcd_flag u_flag (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .set_i  (set_c),
    .clr_i  (flag_clr_i),
    .flag_o (chg_flag_o)
  );

  assign rd_data_o = pins_s;
  assign irq_o     = chg_flag_o & irq_en_i;
endmodule

// File: rtl/port_chg_chk.sv
module port_chg_chk #(
  parameter int unsigned MON_W = 4
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             rd_stb_i,
  input logic             flag_clr_i,
  input logic [MON_W-1:0] chg_en_i,
  input logic             mism,
  input logic             flag
);
  a_r3_set_on_mismatch: assert property (@(posedge clk_i) disable iff (rst_i)
    (mism && !rd_stb_i) |=> flag);

  a_r4_disabled_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
    (chg_en_i == '0) |-> !mism);

  a_r5_read_blocks_set: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_stb_i && !flag) |=> !flag);

  a_r6_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
    (flag && !flag_clr_i) |=> flag);

  a_r6_clear: assert property (@(posedge clk_i) disable iff (rst_i)
    (flag_clr_i && !(mism && !rd_stb_i)) |=> !flag);

  a_r7_reset_clean: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(rst_i) |-> !flag);
endmodule

bind port_change_detect port_chg_chk #(.MON_W(MON_W)) u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .rd_stb_i   (rd_stb_i),
  .flag_clr_i (flag_clr_i),
  .chg_en_i   (chg_en_i),
  .mism       (mism),
  .flag       (chg_flag_o)
);

// File: tb/port_change_detect_tb.sv
module port_change_detect_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_i;
  logic [7:0] pins_i;
  logic [3:0] chg_en_i;
  logic       rd_stb_i, flag_clr_i, irq_en_i;
  logic [7:0] rd_data_o;
  logic       chg_flag_o, irq_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  port_change_detect u_dut (
    .clk_i(clk), .rst_i(rst_i), .pins_i(pins_i), .chg_en_i(chg_en_i),
    .rd_stb_i(rd_stb_i), .flag_clr_i(flag_clr_i), .irq_en_i(irq_en_i),
    .rd_data_o(rd_data_o), .chg_flag_o(chg_flag_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rearm();
    rd_stb_i = 1'b1; cyc(1); rd_stb_i = 1'b0;
    flag_clr_i = 1'b1; cyc(1); flag_clr_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R7 flag after reset", {7'd0, chg_flag_o}, 8'h00);
    chk("R1 read data after reset", rd_data_o, 8'hA5);
    cyc(4);
    chk("R7 no spurious change", {7'd0, chg_flag_o}, 8'h00);
  endtask

  task automatic t_low_pins();
    pins_i = 8'hAA;
    cyc(1);
    chk("R1 one edge not yet visible", rd_data_o, 8'hA5);
    cyc(1);
    chk("R1 two edges visible", rd_data_o, 8'hAA);
    cyc(3);
    chk("R2 low pins ignored", {7'd0, chg_flag_o}, 8'h00);
  endtask

  task automatic t_detect();
    pins_i = 8'hBA;
    cyc(2);
    chk("R3 not before third edge", {7'd0, chg_flag_o}, 8'h00);
    cyc(1);
    chk("R3 flag on third edge", {7'd0, chg_flag_o}, 8'h01);
    chk("R8 irq gated off", {7'd0, irq_o}, 8'h00);
    irq_en_i = 1'b1; #1;
    chk("R8 irq enabled", {7'd0, irq_o}, 8'h01);
    flag_clr_i = 1'b1; cyc(1); flag_clr_i = 1'b0;
    chk("R6 clear loses to persisting mismatch", {7'd0, chg_flag_o}, 8'h01);
    cyc(2);
    chk("R6 flag sticky", {7'd0, chg_flag_o}, 8'h01);
    rd_stb_i = 1'b1; cyc(1); rd_stb_i = 1'b0;
    chk("R6 read alone keeps flag", {7'd0, chg_flag_o}, 8'h01);
    flag_clr_i = 1'b1; cyc(1); flag_clr_i = 1'b0;
    chk("R6 clear after read", {7'd0, chg_flag_o}, 8'h00);
    chk("R8 irq drops with flag", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_disabled();
    chg_en_i = 4'b1101;
    pins_i = 8'h9A;
    cyc(5);
    chk("R4 disabled pin quiet", {7'd0, chg_flag_o}, 8'h00);
    chk("R1 disabled pin readable", rd_data_o, 8'h9A);
    chg_en_i = 4'b1111;
    cyc(1);
    chk("R4 enabling stale pin sets flag", {7'd0, chg_flag_o}, 8'h01);
    rearm();
    chk("R6 rearmed", {7'd0, chg_flag_o}, 8'h00);
  endtask

  task automatic t_read_collide();
    pins_i = 8'h1A;
    cyc(2);
    rd_stb_i = 1'b1; cyc(1); rd_stb_i = 1'b0;
    cyc(3);
    chk("R5 change during read lost", {7'd0, chg_flag_o}, 8'h00);
    chk("R5 read data new", rd_data_o, 8'h1A);
    pins_i = 8'h9A;
    cyc(3);
    chk("R5 snapshot took new level", {7'd0, chg_flag_o}, 8'h01);
    rearm();
  endtask

  task automatic t_clear_with_read();
    flag_clr_i = 1'b1; cyc(1); flag_clr_i = 1'b0;
    pins_i = 8'hDA;
    cyc(2);
    rd_stb_i = 1'b1; flag_clr_i = 1'b1;
    cyc(1);
    rd_stb_i = 1'b0; flag_clr_i = 1'b0;
    cyc(3);
    chk("R5 read plus clear leaves flag low", {7'd0, chg_flag_o}, 8'h00);
  endtask

  task automatic t_reset_again();
    pins_i = 8'h3C;
    flag_clr_i = 1'b0;
    pins_i = 8'h5C;
    cyc(3);
    chk("R3 flag before reset", {7'd0, chg_flag_o}, 8'h01);
    rst_i = 1'b1;
    pins_i = 8'h3C;
    cyc(4);
    rst_i = 1'b0;
    cyc(1);
    chk("R7 flag cleared by reset", {7'd0, chg_flag_o}, 8'h00);
    cyc(4);
    chk("R7 snapshot follows pins", {7'd0, chg_flag_o}, 8'h00);
  endtask

  initial begin
    rst_i = 1'b1; pins_i = 8'hA5; chg_en_i = 4'hF;
    rd_stb_i = 1'b0; flag_clr_i = 1'b0; irq_en_i = 1'b0;
    cyc(6);
    rst_i = 1'b0;
    cyc(1);
    t_reset();
    t_low_pins();
    t_detect();
    t_disabled();
    t_read_collide();
    t_clear_with_read();
    t_reset_again();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule